// File: doc/BRIEF.md
# Dual-Handshake Host Bus Slave Port

This block connects an external host to an internal register space over an asynchronous parallel bus. The block samples every control pin on the rising edge of its own clock. Each access then runs for a fixed number of clock cycles before the port signals completion on a single handshake pin. Read and write latencies differ.

A static mode strap chooses how the shared pins are interpreted. With the strap low, the two strobe pins are independent active-low read and write strobes, and the handshake pin is an active-high ready. With the strap high, the first strobe pin is an active-low data strobe and the second pin selects the direction (high for read, low for write). The handshake pin then acts as an active-low acknowledge. Both styles share the active-low chip select, the address bus and the data bus. The data bus is presented as an input, an output and an output enable, so that a pad ring can build the tri-state buffer.

On the register side, a write produces a one-cycle write-enable pulse carrying the captured address and data. A read produces a one-cycle read-enable pulse, and the register space must answer combinationally in that same cycle.

Top module: `hostbus_slave_port`

## Requirements
- R1: When `mode_sel` is 0, `rd_n` low requests a read, `wr_n` low requests a write, and `hs_out` high means done. When `mode_sel` is 1, `rd_n` is the data strobe, `wr_n` high selects read and low selects write, and `hs_out` low means done. `mode_sel` only changes while no access is in progress.
- R2: A write signals done on the 5th rising clock edge after its strobe falls. The count includes the two-stage input synchronizer.
- R3: A read signals done on the 10th rising clock edge after its strobe falls.
- R4: A write raises `reg_we` for exactly one cycle, after the 3rd rising edge following the strobe. During that cycle `reg_addr` and `reg_wdata` hold the values present on `addr` and `host_din`.
- R5: Address and write data are captured once, at the start of the access. Changes on `addr` or `host_din` after that point do not alter `reg_addr` or `reg_wdata`.
- R6: A read raises `reg_re` for exactly one cycle, after the 3rd rising edge, and samples `reg_rdata` in that cycle. `host_doe` is high exactly while a read shows done, and during that time `host_dout` carries the sampled word.
- R7: Done is held for as long as the strobe stays active. Once the strobe is removed, the handshake returns to idle on the 3rd rising edge, and a new access can start immediately after that.
- R8: While `cs_n` is high, no access starts, and `hs_out` rests at its idle level: 0 when `mode_sel` is 0, and 1 when `mode_sel` is 1.
- R9: When `mode_sel` is 0, holding `rd_n` and `wr_n` low together starts no access.
- R10: After reset, `hs_out` is idle, and `host_doe`, `reg_we` and `reg_re` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 1 | Handshake style strap |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Read strobe (mode 0) or data strobe (mode 1) |
| wr_n | input | 1 | Write strobe (mode 0) or direction select (mode 1) |
| addr | input | AW | Host address |
| host_din | input | DW | Write data from the host |
| host_dout | output | DW | Read data to the host |
| host_doe | output | 1 | Enable for the data bus output buffer |
| hs_out | output | 1 | Ready (mode 0) or acknowledge (mode 1) |
| reg_we | output | 1 | Register write-enable pulse |
| reg_re | output | 1 | Register read-enable pulse |
| reg_addr | output | AW | Captured register address |
| reg_wdata | output | DW | Captured register write data |
| reg_rdata | input | DW | Register read data, valid in the cycle `reg_re` is high |

## Verification
The hardest behaviour to expose from the pins is the one-time capture. A host that follows the protocol keeps the address and data stable, so a port that re-samples them would still look correct. To expose the difference, the stimulus deliberately breaks the hold rule: it inverts `addr` and `host_din` one cycle after the capture edge, then checks `reg_addr` and `reg_wdata` for the rest of the access. The second awkward case is the ambiguous state in which both strobes are low at once. The stimulus holds both strobes low well past the longest latency, then releases them in the same cycle, so that no single strobe is ever seen alone.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;

    typedef enum logic {
        BUS_STROBE_READY = 1'b0,
        BUS_DS_ACK       = 1'b1
    } bus_mode_t;

endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d;
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    assign pipe_d[0] = d_in;

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            assign pipe_d[g] = pipe_q[g-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign d_out = pipe_q[STAGES-1];

endmodule

// File: rtl/hbp_decode.sv
module hbp_decode
    import hbp_pkg::*;
(
    input  logic mode_sel,
    input  logic cs_n_s,
    input  logic strb_a_n_s,   // read strobe / data strobe
    input  logic strb_b_n_s,   // write strobe / direction select
    output logic cs_act,
    output logic rd_req,
    output logic wr_req,
    output logic strb_on
);
    bus_mode_t mode;

    always_comb begin
        mode    = bus_mode_t'(mode_sel);
        cs_act  = !cs_n_s;
        rd_req  = 1'b0;
        wr_req  = 1'b0;
        strb_on = 1'b0;
        if (mode == BUS_STROBE_READY) begin
            // separate strobes; both low together is ambiguous and ignored
            rd_req  = cs_act && !strb_a_n_s &&  strb_b_n_s;
            wr_req  = cs_act &&  strb_a_n_s && !strb_b_n_s;
            strb_on = cs_act && (!strb_a_n_s || !strb_b_n_s);
        end else begin
            // one data strobe, direction taken from the select line
            rd_req  = cs_act && !strb_a_n_s &&  strb_b_n_s;
            wr_req  = cs_act && !strb_a_n_s && !strb_b_n_s;
            strb_on = cs_act && !strb_a_n_s;
        end
    end

endmodule

// File: rtl/hbp_seq.sv
module hbp_seq
    import hbp_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2,
    parameter int WR_LAT      = 5,
    parameter int RD_LAT      = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic          wr_req,
    input  logic          strb_on,
    input  logic [AW-1:0] addr_pin,
    input  logic [DW-1:0] din_pin,
    input  logic [DW-1:0] reg_rdata,
    output logic          done,
    output logic          done_rd,
    output logic          reg_we,
    output logic          reg_re,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] rd_hold
);
    // Latency is counted from the pin edge: SYNC_STAGES edges through the
    // synchronizer, one edge to leave idle, then the countdown, then done.
    localparam int MAX_LAT = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
    localparam int CW      = $clog2(MAX_LAT + 1);
    localparam logic [CW-1:0] WR_LOAD = CW'(WR_LAT - SYNC_STAGES - 2);
    localparam logic [CW-1:0] RD_LOAD = CW'(RD_LAT - SYNC_STAGES - 2);

    typedef struct packed {
        seq_state_t    state;
        logic          is_rd;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          we;
        logic          re;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        seq_d.we = 1'b0;
        seq_d.re = 1'b0;
        case (seq_q.state)
            ST_IDLE: begin
                if (rd_req || wr_req) begin
                    seq_d.state = ST_XFER;
                    seq_d.is_rd = rd_req;
                    seq_d.cnt   = rd_req ? RD_LOAD : WR_LOAD;
                    seq_d.addr  = addr_pin;
                    if (wr_req) seq_d.wdata = din_pin;
                    seq_d.we    = wr_req;
                    seq_d.re    = rd_req;
                end
            end
            ST_XFER: begin
                if (seq_q.re) seq_d.rdata = reg_rdata;
                if (seq_q.cnt == '0) seq_d.state = ST_DONE;
                else                 seq_d.cnt   = seq_q.cnt - 1'b1;
            end
            ST_DONE: begin
                if (!strb_on) seq_d.state = ST_IDLE;
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign done      = (seq_q.state == ST_DONE);
    assign done_rd   = done && seq_q.is_rd;
    assign reg_we    = seq_q.we;
    assign reg_re    = seq_q.re;
    assign reg_addr  = seq_q.addr;
    assign reg_wdata = seq_q.wdata;
    assign rd_hold   = seq_q.rdata;

    // ---- checks ----
    localparam int AGEW = CW + 1;
    logic [AGEW-1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       age_q <= '0;
        else if (seq_q.state == ST_IDLE)  age_q <= '0;
        else if (age_q != '1)             age_q <= age_q + 1'b1;
    end

    // R2 R3
    latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (age_q == (seq_q.is_rd ? AGEW'(RD_LAT - SYNC_STAGES - 1)
                                               : AGEW'(WR_LAT - SYNC_STAGES - 1))));

    // R4
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R6
    re_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);

    // R5
    capture_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state != ST_IDLE && seq_d.state != ST_IDLE) |=>
            ($stable(reg_addr) && $stable(reg_wdata)));

    // R7
    hold_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && strb_on) |=> done);

endmodule

// File: rtl/hostbus_slave_port.sv
module hostbus_slave_port
    import hbp_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2,
    parameter int WR_LAT      = 5,
    parameter int RD_LAT      = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_sel,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] host_din,
    output logic [DW-1:0] host_dout,
    output logic          host_doe,
    output logic          hs_out,
    output logic          reg_we,
    output logic          reg_re,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    input  logic [DW-1:0] reg_rdata
);
    localparam int NCTL = 3;

    logic [NCTL-1:0] ctl_raw, ctl_s;
    logic cs_act, rd_req, wr_req, strb_on;
    logic done, done_rd;

    assign ctl_raw = {cs_n, rd_n, wr_n};

    hbp_sync #(
        .WIDTH  (NCTL),
        .STAGES (SYNC_STAGES),
        .RST_VAL({NCTL{1'b1}})
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (ctl_raw),
        .d_out(ctl_s)
    );

    hbp_decode u_decode (
        .mode_sel  (mode_sel),
        .cs_n_s    (ctl_s[2]),
        .strb_a_n_s(ctl_s[1]),
        .strb_b_n_s(ctl_s[0]),
        .cs_act    (cs_act),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .strb_on   (strb_on)
    );

    hbp_seq #(
        .AW         (AW),
        .DW         (DW),
        .SYNC_STAGES(SYNC_STAGES),
        .WR_LAT     (WR_LAT),
        .RD_LAT     (RD_LAT)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .wr_req   (wr_req),
        .strb_on  (strb_on),
        .addr_pin (addr),
        .din_pin  (host_din),
        .reg_rdata(reg_rdata),
        .done     (done),
        .done_rd  (done_rd),
        .reg_we   (reg_we),
        .reg_re   (reg_re),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .rd_hold  (host_dout)
    );

    logic shown_done;
    always_comb begin
        shown_done = cs_act && done;
        if (bus_mode_t'(mode_sel) == BUS_STROBE_READY) hs_out = shown_done;
        else                                           hs_out = !shown_done;
        host_doe = shown_done && done_rd;
    end

    // R8
    deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |-> (hs_out == mode_sel));

    // R6
    doe_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_doe |-> (hs_out != mode_sel));

    // R6
    we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));

endmodule

// File: tb/sim_hostbus_slave_port.sv
module sim_hostbus_slave_port;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_sel = 1'b0;
    logic          cs_n = 1'b1;
    logic          rd_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] host_din = '0;
    logic [DW-1:0] host_dout;
    logic          host_doe;
    logic          hs_out;
    logic          reg_we;
    logic          reg_re;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata;
    logic [DW-1:0] reg_rdata;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    // behavioural register space: each word derived from its address
    assign reg_rdata = {reg_addr, ~reg_addr};

    hostbus_slave_port u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n),
        .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .host_din(host_din),
        .host_dout(host_dout), .host_doe(host_doe), .hs_out(hs_out),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // one access; k counts rising edges after the strobe falls
    task automatic access(input bit mode, input bit rd, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input int extra, input bit corrupt);
        int lat;
        bit idle_lvl;
        lat      = rd ? 10 : 5;
        idle_lvl = mode;
        mode_sel = mode;
        addr     = a;
        host_din = d;
        cs_n     = 1'b0;
        if (mode == 1'b0) begin
            if (rd) rd_n = 1'b0; else wr_n = 1'b0;
        end else begin
            wr_n = rd;
            rd_n = 1'b0;
        end
        for (int k = 1; k <= lat + extra; k++) begin
            bit exp_done;
            tick();
            if (corrupt && k == 4) begin
                addr     = ~a;
                host_din = ~d;
            end
            exp_done = (k >= lat);
            chk(hs_out == (exp_done ? !idle_lvl : idle_lvl), rd ? "R3 R1" : "R2 R1",
                "hs_out", hs_out, exp_done ? !idle_lvl : idle_lvl);
            chk(reg_we == (!rd && k == 3), "R4", "reg_we", reg_we, (!rd && k == 3));
            chk(reg_re == (rd && k == 3), "R6", "reg_re", reg_re, (rd && k == 3));
            chk(host_doe == (rd && exp_done), "R6", "host_doe", host_doe, (rd && exp_done));
            if (!rd && k == 3) begin
                chk(reg_addr == a, "R4", "reg_addr", reg_addr, a);
                chk(reg_wdata == d, "R4", "reg_wdata", reg_wdata, d);
            end
            if (!rd && corrupt && k >= 4) begin
                chk(reg_addr == a, "R5", "reg_addr", reg_addr, a);
                chk(reg_wdata == d, "R5", "reg_wdata", reg_wdata, d);
            end
            if (rd && exp_done)
                chk(host_dout == {a, ~a}, "R6", "host_dout", host_dout, {a, ~a});
        end
        rd_n = 1'b1;
        wr_n = 1'b1;
        addr = a;
        for (int r = 1; r <= 3; r++) begin
            bit exp_done;
            tick();
            exp_done = (r < 3);
            chk(hs_out == (exp_done ? !idle_lvl : idle_lvl), "R7", "hs_out release",
                hs_out, exp_done ? !idle_lvl : idle_lvl);
            chk(host_doe == (rd && exp_done), "R7", "host_doe release",
                host_doe, (rd && exp_done));
        end
    endtask

    // strobes held with no valid access; nothing may happen
    task automatic quiet_window(input bit mode, input string req);
        for (int k = 1; k <= 14; k++) begin
            tick();
            chk(hs_out == mode, req, "hs_out", hs_out, mode);
            chk(!reg_we && !reg_re, req, "reg_we|reg_re", {reg_we, reg_re}, 0);
            chk(!host_doe, req, "host_doe", host_doe, 0);
        end
        rd_n = 1'b1;
        wr_n = 1'b1;
        cs_n = 1'b0;
        repeat (3) tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R10
        chk(hs_out == 1'b0, "R10", "hs_out", hs_out, 0);
        chk(!host_doe, "R10", "host_doe", host_doe, 0);
        chk(!reg_we && !reg_re, "R10", "reg_we|reg_re", {reg_we, reg_re}, 0);

        // strobe/ready style
        access(1'b0, 1'b0, 8'h3c, 16'hbeef, 0, 1'b0);
        access(1'b0, 1'b1, 8'h5a, 16'h0000, 0, 1'b0);
        access(1'b0, 1'b0, 8'hf0, 16'h1234, 0, 1'b1);   // R5 hold violation
        access(1'b0, 1'b1, 8'h01, 16'h0000, 6, 1'b0);   // R7 long hold

        // R9 both strobes low together
        mode_sel = 1'b0; cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
        quiet_window(1'b0, "R9");

        // R8 deselected, each style
        mode_sel = 1'b0; cs_n = 1'b1; rd_n = 1'b0;
        quiet_window(1'b0, "R8");
        mode_sel = 1'b1; cs_n = 1'b1; rd_n = 1'b0; wr_n = 1'b0;
        quiet_window(1'b1, "R8");

        // data-strobe / acknowledge style (R1)
        access(1'b1, 1'b0, 8'h77, 16'hcafe, 0, 1'b0);
        access(1'b1, 1'b1, 8'ha5, 16'h0000, 0, 1'b0);
        access(1'b1, 1'b0, 8'h0f, 16'h8001, 3, 1'b1);
        access(1'b1, 1'b1, 8'hff, 16'h0000, 4, 1'b0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R10 actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule